// File: doc/BRIEF.md
# Banked-Register Sine Oscillator

This block is a numerically controlled oscillator for pulse sequencers that switch frequency and phase on every instruction. A host fills two small banks, one of sixteen 32-bit tuning words and one of sixteen 12-bit phase offsets. On every clock, a 4-bit frequency index and a 4-bit phase index from the sequencer pick one entry from each bank. A 32-bit accumulator advances by the chosen tuning word. The chosen offset is added to the accumulator's top twelve bits, and the sum addresses a computed sine shape that yields a signed 10-bit sample.

An active-low gate turns the output on and off. When the gate is off, the sample is held at zero (mid-scale) and the last waveform value is not frozen. The accumulator is never cleared by a frequency change, so a hop between tuning words keeps the phase continuous. With a tuning word of zero the accumulator stands still, and the phase offsets alone then set a constant output level.

Host loading is sequential. A start pulse names the target bank and returns the write pointer to entry 0. Each later write strobe stores one word and moves the pointer on by one.

Top module: `dds_nco`

## Requirements
- R1: Sixteen 32-bit tuning registers exist, and `freq_sel` chooses which one the accumulator adds on each clock.
- R2: Sixteen 12-bit phase-offset registers exist, and `phase_sel` chooses which one is added to the phase.
- R3: The 32-bit accumulator wraps modulo 2^32 as it advances. A change of `freq_sel` never clears or reloads it, so the phase stays continuous.
- R4: The lookup phase is (accumulator bits 31..20 + selected offset) modulo 4096, formed after accumulation and before the amplitude lookup.
- R5: A `host_start` pulse selects the bank given by `host_bank` (0 = tuning words, 1 = phase offsets) and sets the write pointer to 0. A write in that same cycle is ignored. Each `host_we` stores `host_wdata` at the pointer (bits 11..0 for offsets) and advances the pointer, which wraps from 15 back to 0.
- R6: `gate_n` = 1 forces `sample` to 0. `gate_n` = 0 lets the waveform through.
- R7: For phase p, with u = p[10:0], the magnitude is floor(u*(2048-u)*511 / 2^20). The sample is that magnitude when p[11] = 0 and its negation when p[11] = 1. The value -512 never occurs.
- R8: A change on `freq_sel`, `phase_sel` or `gate_n` first affects `sample` after the fourth rising clock edge. Selects applied in the same cycle take effect on the same sample.
- R9: With a selected tuning word of 0, the accumulator holds its value, so a fixed phase selection gives a constant sample.
- R10: Reset clears the accumulator and every bank entry, selects the tuning bank with pointer 0, gates the pipeline off and sets `sample` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_start | input | 1 | Selects the bank and restarts the write pointer |
| host_bank | input | 1 | Bank chosen on start: 0 tuning, 1 phase |
| host_we | input | 1 | Write strobe, stores the word and advances the pointer |
| host_wdata | input | 32 | Word to store |
| freq_sel | input | 4 | Tuning register index |
| phase_sel | input | 4 | Phase-offset register index |
| gate_n | input | 1 | Output gate, 0 = on, 1 = off |
| sample | output | 10 | Signed amplitude sample |

## Verification
The hardest condition to reach from the ports is a hop of frequency and phase in the same cycle while the accumulator is already far from zero. This case must show both continuity and aligned timing of the two selects. The stimulus gets there by loading random words into both banks and then running thousands of cycles in which the selects, the gate and host reloads change at random. A cycle model drives the expectation. Directed steps cover the constant level at a zero tuning word, the exact four-edge latency, the pointer wrap on a seventeenth write and the ground level while gated.

// File: rtl/dds_nco.sv
module dds_nco #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12,
  parameter int AMP_W = 10,
  parameter int NREG  = 16,
  parameter int SEL_W = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_start,
  input  logic                    host_bank,
  input  logic                    host_we,
  input  logic [ACC_W-1:0]        host_wdata,
  input  logic [SEL_W-1:0]        freq_sel,
  input  logic [SEL_W-1:0]        phase_sel,
  input  logic                    gate_n,
  output logic signed [AMP_W-1:0] sample
);
  localparam int HALF  = 2 ** (PH_W - 1);
  localparam int AMAX  = 2 ** (AMP_W - 1) - 1;
  localparam int SHIFT = 2 * (PH_W - 2);

  logic [ACC_W-1:0] ftw  [NREG];
  logic [PH_W-1:0]  poff [NREG];
  logic             bank;
  logic [SEL_W-1:0] wptr;

  logic [SEL_W-1:0] fsel_q, psel_q;
  logic [2:0]       gate_d;
  logic [ACC_W-1:0] acc;
  logic [PH_W-1:0]  poff_q, addr;
  logic signed [AMP_W-1:0] sample_q;

  function automatic logic signed [AMP_W-1:0] shape(input logic [PH_W-1:0] p);
    logic [63:0]      prod;
    logic [AMP_W-1:0] mag;
    prod = 64'(p[PH_W-2:0]) * 64'(HALF - int'(p[PH_W-2:0])) * 64'(AMAX);
    mag  = AMP_W'(prod >> SHIFT);
    return p[PH_W-1] ? -$signed(mag) : $signed(mag);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank <= 1'b0;
      wptr <= '0;
      for (int i = 0; i < NREG; i++) begin
        ftw[i]  <= '0;
        poff[i] <= '0;
      end
    end else if (host_start) begin
      bank <= host_bank;
      wptr <= '0;
    end else if (host_we) begin
      if (bank) poff[wptr] <= host_wdata[PH_W-1:0];
      else      ftw[wptr]  <= host_wdata;
      wptr <= (wptr == SEL_W'(NREG - 1)) ? '0 : wptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsel_q   <= '0;
      psel_q   <= '0;
      gate_d   <= '1;
      acc      <= '0;
      poff_q   <= '0;
      addr     <= '0;
      sample_q <= '0;
    end else begin
      fsel_q   <= freq_sel;
      psel_q   <= phase_sel;
      gate_d   <= {gate_d[1:0], gate_n};
      acc      <= acc + ftw[fsel_q];
      poff_q   <= poff[psel_q];
      addr     <= acc[ACC_W-1 -: PH_W] + poff_q;
      sample_q <= gate_d[2] ? '0 : shape(addr);
    end
  end

  assign sample = sample_q;

  assert_gate_ground_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gate_d[2] |=> sample_q == '0);

  assert_amp_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_q != {1'b1, {(AMP_W-1){1'b0}}});

  assert_zero_word_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ftw[fsel_q] == '0) |=> $stable(acc));

  assert_ptr_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    host_start |=> wptr == '0);

  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && !host_start && wptr != SEL_W'(NREG - 1)) |=> wptr == $past(wptr) + 1'b1);
endmodule

// File: tb/test_dds_nco.sv
`timescale 1ns/1ps
module test_dds_nco;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_start = 1'b0, host_bank = 1'b0, host_we = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [3:0]  freq_sel = '0, phase_sel = '0;
  logic        gate_n = 1'b0;
  logic signed [9:0] sample;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dds_nco i_dds_nco (.clk(clk), .rst_n(rst_n), .host_start(host_start), .host_bank(host_bank),
    .host_we(host_we), .host_wdata(host_wdata), .freq_sel(freq_sel), .phase_sel(phase_sel),
    .gate_n(gate_n), .sample(sample));

  function automatic int ref_amp(logic [11:0] p);
    int u, m;
    u = int'(p[10:0]);
    m = (u * (2048 - u) * 511) >>> 20;
    return p[11] ? -m : m;
  endfunction

  logic [31:0] m_ftw [16];
  logic [11:0] m_poff [16];
  logic        m_bank;
  logic [3:0]  m_ptr, m_fs, m_ps;
  logic [2:0]  m_g;
  logic [31:0] m_acc;
  logic [11:0] m_po, m_addr;
  int          m_out;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_bank <= 0; m_ptr <= 0; m_fs <= 0; m_ps <= 0; m_g <= 3'b111;
      m_acc <= 0; m_po <= 0; m_addr <= 0; m_out <= 0;
      for (int i = 0; i < 16; i++) begin m_ftw[i] <= 0; m_poff[i] <= 0; end
    end else begin
      if (host_start) begin m_bank <= host_bank; m_ptr <= 0; end
      else if (host_we) begin
        if (m_bank) m_poff[m_ptr] <= host_wdata[11:0]; else m_ftw[m_ptr] <= host_wdata;
        m_ptr <= m_ptr + 4'd1;
      end
      m_fs <= freq_sel; m_ps <= phase_sel; m_g <= {m_g[1:0], gate_n};
      m_acc <= m_acc + m_ftw[m_fs];
      m_po <= m_poff[m_ps];
      m_addr <= m_acc[31:20] + m_po;
      m_out <= m_g[2] ? 0 : ref_amp(m_addr);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(int act, int exp, string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) tick();
    check(int'(sample), 0, "R10 sample during reset");
    rst_n = 1'b1;
    repeat (2) tick();
    check(int'(sample), 0, "R10 sample after reset");

    host_start = 1; host_bank = 1; tick(); host_start = 0;
    for (int k = 0; k < 16; k++) begin host_we = 1; host_wdata = 32'(k * 256); tick(); end
    host_we = 0;

    phase_sel = 4'd4;
    repeat (4) tick();
    check(int'(sample), 511, "R2 R9 offset 1024 level");
    for (int k = 0; k < 4; k++) begin tick(); check(int'(sample), 511, "R9 constant level"); end

    phase_sel = 4'd12;
    for (int k = 0; k < 3; k++) begin tick(); check(int'(sample), 511, "R8 old value before fourth edge"); end
    tick(); check(int'(sample), -511, "R8 new value at fourth edge");
    phase_sel = 4'd2;
    repeat (4) tick();
    check(int'(sample), 383, "R7 magnitude at phase 512");

    host_start = 1; host_bank = 0; host_we = 1; host_wdata = 32'hFFFF_FFFF; tick(); host_start = 0;
    for (int k = 0; k < 16; k++) begin host_wdata = 32'h0 + 32'(k); tick(); end
    host_wdata = 32'h0010_0000; tick(); host_we = 0;
    freq_sel = 4'd1;
    repeat (6) tick();
    check(int'(sample), m_out, "R5 start ignores write, tuning entry 1");
    freq_sel = 4'd0;
    repeat (5) tick();
    for (int k = 0; k < 4; k++) begin tick(); check(int'(sample), m_out, "R5 wrapped write at entry 0"); end

    gate_n = 1;
    repeat (4) tick();
    for (int k = 0; k < 6; k++) begin tick(); check(int'(sample), 0, "R6 gated output at ground"); end
    gate_n = 0;
    repeat (4) tick();
    check(int'(sample), m_out, "R6 output restored");

    host_start = 1; host_bank = 0; tick(); host_start = 0;
    for (int k = 0; k < 16; k++) begin host_we = 1; host_wdata = $urandom >> (k % 8); tick(); end
    host_we = 0;
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom % 100);
      host_start = 0; host_we = 0;
      if (r < 12) begin freq_sel = 4'($urandom); phase_sel = 4'($urandom); end
      else if (r < 18) freq_sel = 4'($urandom);
      else if (r < 22) gate_n = ~gate_n;
      else if (r < 25) begin host_start = 1; host_bank = 1'($urandom); host_we = 1'($urandom); end
      else if (r < 33) begin host_we = 1; host_wdata = $urandom; end
      tick();
      check(int'(sample), m_out, "R1 R3 R4 R7 R8 random hops");
    end
    host_start = 0; host_we = 0;
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule